// File: doc/BRIEF.md
# Stereo Sample Transmit Port

This block is a register-mapped transmit port that feeds a pair of 16-bit DACs at a fixed sample rate. A processor uses a simple write bus to reach two registers. One is a control register that holds the transmitter enable and the interrupt enable. The other is a 32-bit data register that holds one stereo frame. The low half of the frame is the left channel and the high half is the right channel. Both halves are two's-complement.

A free-running divider in the sound clock domain produces one sample tick every `TICK_DIV` clocks. With the default of 512 and a 12.288 MHz clock, this gives 24 kHz. On each tick, a pending frame goes to the DAC outputs in offset binary, together with a one-cycle valid strobe. The ready and pending status flags then return to their idle values, and an optional one-cycle interrupt pulse asks the processor for the next frame. The flags and the interrupt follow the tick, not the timing of the writes. Software therefore refills the port once per tick.

Register select: `0` is control and `1` is transmit data. In the control register:
- bit 26 is the enable;
- bit 23 is the interrupt enable;
- bit 1 reads back the ready flag;
- bit 3 reads back the pending (shifter-full) flag.

Top module: `audio_tx_port`

## Requirements
- R1: After reset, the control register reads 0 (ready and pending both clear), both DAC outputs are 16'h8000, and the strobe and interrupt are low.
- R2: A control write that takes bit 26 from 0 to 1 sets ready (bit 1) and clears pending (bit 3). Any frame still pending is discarded. The tick divider restarts, so the first tick comes `TICK_DIV` clocks after the write edge.
- R3: While bit 26 is set, ticks repeat every `TICK_DIV` clocks. While it is clear, the divider stays at zero, and neither the strobe nor the interrupt is ever asserted.
- R4: A write to the data register (select 1) clears ready and sets pending, whether or not the port is enabled.
- R5: At a tick with pending set, `dac_valid_o` is high for one cycle. `dac_left_o` is data[15:0] + 16'h8000 and `dac_right_o` is data[31:16] + 16'h8000, each taken modulo 2^16.
- R6: Every tick leaves ready set and pending clear, whether or not a frame was sent.
- R7: At a tick with pending clear, the strobe stays low and both DAC outputs keep their previous values. The outputs never change without the strobe.
- R8: When bit 23 is set, `tx_irq_o` pulses for one cycle at each tick, including ticks that send nothing. When bit 23 is clear, the interrupt never pulses.
- R9: Control reads return the stored bits with bits 1 and 3 replaced by the live flags. Values written to bits 1 and 3 have no effect.
- R10: If a data write lands in the same cycle as a tick, the tick sends the previous pending frame. The new frame is left pending, with ready clear.
- R11: A control write with bit 26 already set leaves the flags and the divider phase unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sound clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write select: 0 control, 1 data |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 1 | Read select: 0 control, 1 data |
| rd_data_o | output | 32 | Combinational read data |
| dac_valid_o | output | 1 | One-cycle strobe when a new sample pair is presented |
| dac_left_o | output | 16 | Left sample, offset binary |
| dac_right_o | output | 16 | Right sample, offset binary |
| tx_irq_o | output | 1 | One-cycle transmit interrupt pulse per tick |

## Verification
The bench aims a data write at the exact cycle of a tick. A design that lets the write win the tick would send the new frame at once or drop the old one. A design that lets the tick win the flags would show the port idle with a frame still unsent.

It rewrites the control register while the port is running. A design that decodes the enable as a level instead of an edge would restart the divider and throw away the pending frame.

It also checks these corners:
- It disables the port with a frame pending and then re-enables it. A design that keeps the stale frame would emit an unexpected strobe.
- It uses the frames 0x7FFF_8000 and 0xFFFF_7FFF. These catch a sign-extension or carry mistake in the offset conversion.
- It lets ticks pass with nothing pending. A design that strobes or drifts its outputs on empty ticks would show up there.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam int DATA_W   = 32;
  localparam int SAMPLE_W = 16;

  localparam int EN_BIT     = 26;
  localparam int IRQ_EN_BIT = 23;
  localparam int READY_BIT  = 1;
  localparam int FULL_BIT   = 3;

  localparam logic [DATA_W-1:0] STATUS_MASK =
      (DATA_W'(1) << READY_BIT) | (DATA_W'(1) << FULL_BIT);

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  localparam logic [SAMPLE_W-1:0] MIDSCALE = SAMPLE_W'(1) << (SAMPLE_W - 1);

  function automatic logic [SAMPLE_W-1:0] to_offset(input logic [SAMPLE_W-1:0] s);
    return s + MIDSCALE;
  endfunction
endpackage

// File: rtl/tx_tick_div.sv
module tx_tick_div #(
  parameter int TICK_DIV = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_ctrl_regs.sv
module tx_ctrl_regs
  import audio_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              tick_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              en_o,
  output logic              irq_en_o,
  output logic              ready_o,
  output logic              full_o
);
  logic [DATA_W-1:0] ctrl_q, data_q;
  logic ready_q, full_q;
  logic ctrl_wr, data_wr, en_rise;

  assign ctrl_wr = wr_en_i && (wr_addr_i == SEL_CTRL);
  assign data_wr = wr_en_i && (wr_addr_i == SEL_DATA);
  assign en_rise = ctrl_wr && wr_data_i[EN_BIT] && !ctrl_q[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wr_data_i & ~STATUS_MASK;
      if (data_wr) data_q <= wr_data_i;
    end
  end

  // data write outranks the tick so a frame landing on a tick stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      full_q  <= 1'b0;
    end else if (data_wr) begin
      ready_q <= 1'b0;
      full_q  <= 1'b1;
    end else if (en_rise || tick_i) begin
      ready_q <= 1'b1;
      full_q  <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign data_o   = data_q;
  assign en_o     = ctrl_q[EN_BIT];
  assign irq_en_o = ctrl_q[IRQ_EN_BIT];
  assign ready_o  = ready_q;
  assign full_o   = full_q;
endmodule

// File: rtl/tx_sample_out.sv
module tx_sample_out
  import audio_tx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                full_i,
  input  logic                irq_en_i,
  input  logic [DATA_W-1:0]   frame_i,
  output logic                valid_o,
  output logic                irq_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  logic send;
  assign send = tick_i && full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      irq_o   <= 1'b0;
      left_o  <= MIDSCALE;
      right_o <= MIDSCALE;
    end else begin
      valid_o <= send;
      irq_o   <= tick_i && irq_en_i;
      if (send) begin
        left_o  <= to_offset(frame_i[SAMPLE_W-1:0]);
        right_o <= to_offset(frame_i[2*SAMPLE_W-1:SAMPLE_W]);
      end
    end
  end
endmodule

// File: rtl/audio_tx_port.sv
module audio_tx_port
  import audio_tx_pkg::*;
#(
  parameter int TICK_DIV = 512
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                dac_valid_o,
  output logic [SAMPLE_W-1:0] dac_left_o,
  output logic [SAMPLE_W-1:0] dac_right_o,
  output logic                tx_irq_o
);
  logic [DATA_W-1:0] ctrl_q, data_q;
  logic en_q, irq_en_q, ready_q, full_q, tick;

  tx_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (en_q),
    .tick_o(tick)
  );

  tx_ctrl_regs u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .tick_i   (tick),
    .ctrl_o   (ctrl_q),
    .data_o   (data_q),
    .en_o     (en_q),
    .irq_en_o (irq_en_q),
    .ready_o  (ready_q),
    .full_o   (full_q)
  );

  tx_sample_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .full_i  (full_q),
    .irq_en_i(irq_en_q),
    .frame_i (data_q),
    .valid_o (dac_valid_o),
    .irq_o   (tx_irq_o),
    .left_o  (dac_left_o),
    .right_o (dac_right_o)
  );

  always_comb begin
    if (rd_addr_i == SEL_DATA) rd_data_o = data_q;
    else begin
      rd_data_o = ctrl_q;
      rd_data_o[READY_BIT] = ready_q;
      rd_data_o[FULL_BIT]  = full_q;
    end
  end
endmodule

// File: rtl/audio_tx_port_chk.sv
module audio_tx_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_addr_i,
  input logic        dac_valid_o,
  input logic [15:0] dac_left_o,
  input logic [15:0] dac_right_o,
  input logic        tx_irq_o,
  input logic        en_q,
  input logic        irq_en_q,
  input logic        ready_q,
  input logic        full_q,
  input logic        tick
);
  // R3
  idle_no_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!dac_valid_o && !tx_irq_o));

  // R7
  hold_without_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_valid_o |-> ($stable(dac_left_o) && $stable(dac_right_o)));

  // R5
  strobe_needs_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_valid_o |-> $past(full_q));

  // R8
  irq_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> $past(irq_en_q));

  // R4
  data_write_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i) |=> (full_q && !ready_q));

  // R6
  tick_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !(wr_en_i && wr_addr_i)) |=> (ready_q && !full_q));

  // R6
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ready_q, full_q}));
endmodule

bind audio_tx_port audio_tx_port_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .dac_valid_o(dac_valid_o),
  .dac_left_o (dac_left_o),
  .dac_right_o(dac_right_o),
  .tx_irq_o   (tx_irq_o),
  .en_q       (en_q),
  .irq_en_q   (irq_en_q),
  .ready_q    (ready_q),
  .full_q     (full_q),
  .tick       (tick)
);

// File: tb/tb_audio_tx_port.sv
`timescale 1ns/1ps
module tb_audio_tx_port;
  localparam int DIV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_addr = 1'b0;
  logic [31:0] rd_data;
  logic        dac_valid;
  logic [15:0] dac_left, dac_right;
  logic        tx_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  audio_tx_port #(.TICK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dac_valid_o(dac_valid), .dac_left_o(dac_left), .dac_right_o(dac_right),
    .tx_irq_o(tx_irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [31:0] f);
    return {f[31:16] + 16'h8000, f[15:0] + 16'h8000};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && dac_valid && !done) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected strobe", {dac_right, dac_left}, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk({dac_right, dac_left} == e, "R5 sample pair", {dac_right, dac_left}, e);
      end
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_irq(inout int c);
    do begin @(negedge clk); c++; end while (!tx_irq && c < 4*DIV);
  endtask

  task automatic wait_valid(inout int c);
    do begin @(negedge clk); c++; end while (!dac_valid && c < 4*DIV);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    #(20*60000);
    chk(0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int c;
    logic [31:0] pats[4];
    pats[0] = 32'h7FFF_8000; pats[1] = 32'h0000_0000;
    pats[2] = 32'h1234_FFFF; pats[3] = 32'hFFFF_7FFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    rd(1'b0, r);
    chk(r == 32'h0, "R1 ctrl reset", r, 32'h0);
    chk({dac_right, dac_left} == 32'h8000_8000, "R1 dac reset", {dac_right, dac_left}, 32'h8000_8000);
    chk({dac_valid, tx_irq} == 2'b00, "R1 strobe/irq reset", {dac_valid, tx_irq}, 32'h0);

    // R2 R9: enable with irq, status bits in write ignored
    wr(1'b0, 32'h0480_000A);
    rd(1'b0, r);
    chk(r == 32'h0480_0002, "R9 R2 ctrl after enable", r, 32'h0480_0002);
    c = 0; wait_irq(c);
    chk(c == DIV, "R2 first tick delay", c, DIV);
    chk(dac_valid == 1'b0, "R7 empty tick no strobe", dac_valid, 1'b0);
    c = 0; wait_irq(c);
    chk(c == DIV, "R3 tick period", c, DIV);

    // R4 R5 R6 patterns
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(conv(pats[i]));
      wr(1'b1, pats[i]);
      rd(1'b0, r);
      chk(r == 32'h0480_0008, "R4 flags after data write", r, 32'h0480_0008);
      c = 1; wait_irq(c);
      chk(c == DIV, "R8 irq per tick", c, DIV);
      chk(dac_valid == 1'b1, "R5 strobe at tick", dac_valid, 1'b1);
      @(negedge clk);
      chk(dac_valid == 1'b0, "R5 strobe one cycle", dac_valid, 1'b0);
      rd(1'b0, r);
      chk(r == 32'h0480_0002, "R6 flags after tick", r, 32'h0480_0002);
      c = 1; wait_irq(c);
      chk(dac_valid == 1'b0, "R7 empty tick no strobe", dac_valid, 1'b0);
      chk({dac_right, dac_left} == conv(pats[i]), "R7 outputs held", {dac_right, dac_left}, conv(pats[i]));
    end

    // overwrite before tick: last frame only
    wr(1'b1, 32'hAAAA_5555);
    exp_q.push_back(conv(32'h0102_0304));
    wr(1'b1, 32'h0102_0304);
    c = 2; wait_irq(c);
    chk(dac_valid == 1'b1, "R5 overwritten frame sent", dac_valid, 1'b1);

    // R10 write in the tick cycle
    exp_q.push_back(conv(32'h1111_2222));
    wr(1'b1, 32'h1111_2222);
    repeat (DIV-2) @(negedge clk);
    exp_q.push_back(conv(32'h3333_4444));
    wr(1'b1, 32'h3333_4444);
    chk(dac_valid == 1'b1, "R10 old frame sent at tick", dac_valid, 1'b1);
    rd(1'b0, r);
    chk(r == 32'h0480_0008, "R10 new frame pending", r, 32'h0480_0008);
    c = 0; wait_valid(c);
    chk(c == DIV, "R10 new frame next tick", c, DIV);

    // R11 rewrite while enabled, irq off
    exp_q.push_back(conv(32'h5A5A_A5A5));
    wr(1'b1, 32'h5A5A_A5A5);
    wr(1'b0, 32'h0400_0000);
    rd(1'b0, r);
    chk(r == 32'h0400_0008, "R11 flags kept", r, 32'h0400_0008);
    c = 2; wait_valid(c);
    chk(c == DIV, "R11 phase kept", c, DIV);
    chk(tx_irq == 1'b0, "R8 irq disabled", tx_irq, 1'b0);

    // R3 disable
    wr(1'b0, 32'h0080_0000);
    c = 0;
    for (int k = 0; k < 3*DIV; k++) begin
      @(negedge clk);
      if (dac_valid || tx_irq) c++;
    end
    chk(c == 0, "R3 no events when disabled", c, 0);
    wr(1'b1, 32'hDEAD_BEEF);
    rd(1'b0, r);
    chk(r == 32'h0080_0008, "R4 write while disabled", r, 32'h0080_0008);
    rd(1'b1, r);
    chk(r == 32'hDEAD_BEEF, "R9 data readback", r, 32'hDEAD_BEEF);

    // R2 re-enable drops stale frame
    wr(1'b0, 32'h0480_0000);
    rd(1'b0, r);
    chk(r == 32'h0480_0002, "R2 re-enable flags", r, 32'h0480_0002);
    c = 0; wait_irq(c);
    chk(c == DIV, "R2 divider restart", c, DIV);
    chk(dac_valid == 1'b0, "R2 stale frame dropped", dac_valid, 1'b0);

    @(negedge clk);
    chk(exp_q.size() == 0, "R5 all frames sent", exp_q.size(), 0);
    finish_run();
  end
endmodule